// File: doc/BRIEF.md
# Staircase Soft-Start and Enable Sequencer

This block produces the digital reference code that a DAC turns into the error-amplifier reference of a step-down converter. At each start-up the code climbs from zero to full scale in equal steps. The step counter advances only on a single-cycle switching tick, so the length of the start-up ramp follows the switching frequency. With 64 steps of 32 ticks each, the ramp takes 2048 switching periods, which is 8 ms at a 250 kHz switching clock.

The same block decides when the power stage may run. The stage runs only while the enable request and the supply-good flag are both high and the block is not in thermal shutdown. Thermal shutdown takes a digitized junction temperature and applies a hysteretic trip. Any loss of a start condition returns the code to zero. The ramp then starts again from the first step once every condition holds again. A done flag reports that the reference has reached full scale.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `refCode` is 0, and `stageEn` and `softDone` are both low.
- R2: While `enReq` or `supplyOk` is low, `stageEn` stays low and `refCode` stays 0, however many `swTick` pulses arrive.
- R3: The clock edge that first samples `enReq`, `supplyOk` and a cool thermal state together raises `stageEn`, with `refCode` still 0 (the first step).
- R4: While running, `refCode` increases by exactly one after every 32nd sampled `swTick` pulse. Cycles without `swTick` do not advance it.
- R5: `refCode` never exceeds full scale (64). It stays at 64 while running. `softDone` is high exactly when `refCode` is 64.
- R6: A low `enReq` or `supplyOk` drops `stageEn` in the same cycle and clears `refCode` to 0 at the next clock edge. A later restart needs 32 fresh ticks to reach code 1.
- R7: `tempCode` is an unsigned temperature in degrees C. A value strictly above 150 sets the overtemperature state at the next clock edge. That state forces `stageEn` low and clears `refCode` to 0 one edge later. A value of exactly 150 does not trip.
- R8: The overtemperature state persists while `tempCode` stays above 120. Once `tempCode` is at or below 120, the state clears, and the ramp restarts from code 0 without any other input changing.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swTick | input | 1 | Single-cycle pulse, once per switching period |
| enReq | input | 1 | Enable request, high to run |
| supplyOk | input | 1 | Supply above undervoltage threshold |
| tempCode | input | 8 | Junction temperature, unsigned degrees C |
| refCode | output | 7 | Reference code for the DAC, 0 to 64 |
| stageEn | output | 1 | Power stage enable |
| softDone | output | 1 | Reference has reached full scale |

## Verification
The hardest state to reach from the ports is the band between the two thermal thresholds while the block is tripped. The bench first ramps partway, then raises the temperature above the trip level. It then lowers the temperature into the band and ticks repeatedly to show that nothing restarts. Only a further drop to the release level restarts the ramp. The full-scale boundary needs 2048 tick pulses, so the bench counts its own ticks. It samples exactly at tick 2047 and at tick 2048, then keeps ticking to confirm saturation.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // force code and sub-counter to zero
    logic advance;  // one switching tick counted
  } ssStrobe_t;

  typedef enum logic [0:0] {
    SS_IDLE = 1'b0,
    SS_RUN  = 1'b1
  } ssState_e;

endpackage

// File: rtl/ss_datapath.sv
module ss_datapath
  import ss_pkg::*;
#(
  parameter int STEPS          = 64,
  parameter int TICKS_PER_STEP = 32,
  localparam int SUB_W  = $clog2(TICKS_PER_STEP),
  localparam int CODE_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssStrobe_t         strobe,
  output logic [CODE_W-1:0] refCode,
  output logic              atFull
);

  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(TICKS_PER_STEP - 1);
  localparam logic [CODE_W-1:0] CODE_FULL = CODE_W'(STEPS);

  logic [SUB_W-1:0]  subCnt;
  logic [CODE_W-1:0] codeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt  <= '0;
      codeReg <= '0;
    end else if (strobe.clear) begin
      subCnt  <= '0;
      codeReg <= '0;
    end else if (strobe.advance) begin
      if (subCnt == SUB_LAST) begin
        subCnt  <= '0;
        codeReg <= codeReg + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  assign refCode = codeReg;
  assign atFull  = (codeReg == CODE_FULL);

  // R5
  code_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeReg <= CODE_FULL);

  // R4
  code_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeReg != $past(codeReg)) |->
      ((codeReg == CODE_W'($past(codeReg) + 1'b1)) || (codeReg == '0)));

endmodule

// File: rtl/ss_control.sv
module ss_control
  import ss_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int TRIP_HI = 150,
  parameter int TRIP_LO = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swTick,
  input  logic              enReq,
  input  logic              supplyOk,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              atFull,
  output ssStrobe_t         strobe,
  output logic              stageEn
);

  localparam logic [TEMP_W-1:0] HOT_SET = TEMP_W'(TRIP_HI);
  localparam logic [TEMP_W-1:0] HOT_CLR = TEMP_W'(TRIP_LO);

  logic     hotFlag;
  logic     runOk;
  ssState_e state;

  // hysteretic thermal trip
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   hotFlag <= 1'b0;
    else if (tempCode > HOT_SET) hotFlag <= 1'b1;
    else if (tempCode <= HOT_CLR) hotFlag <= 1'b0;
  end

  assign runOk = enReq & supplyOk & ~hotFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      state <= SS_IDLE;
    else if (!runOk) state <= SS_IDLE;
    else            state <= SS_RUN;
  end

  always_comb begin
    strobe.clear   = (state == SS_IDLE) | ~runOk;
    strobe.advance = (state == SS_RUN) & runOk & swTick & ~atFull;
  end

  assign stageEn = (state == SS_RUN) & runOk;

  // R7
  hot_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode > HOT_SET) |=> !stageEn);

  // R8
  hot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hotFlag && (tempCode > HOT_CLR)) |=> hotFlag);

  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stageEn) |-> $past(state == SS_IDLE));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int STEPS          = 64,
  parameter int TICKS_PER_STEP = 32,
  parameter int TEMP_W         = 8,
  parameter int TRIP_HI        = 150,
  parameter int TRIP_LO        = 120,
  localparam int CODE_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swTick,
  input  logic              enReq,
  input  logic              supplyOk,
  input  logic [TEMP_W-1:0] tempCode,
  output logic [CODE_W-1:0] refCode,
  output logic              stageEn,
  output logic              softDone
);

  ssStrobe_t strobe;
  logic      atFull;

  ss_control #(
    .TEMP_W (TEMP_W),
    .TRIP_HI(TRIP_HI),
    .TRIP_LO(TRIP_LO)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .swTick  (swTick),
    .enReq   (enReq),
    .supplyOk(supplyOk),
    .tempCode(tempCode),
    .atFull  (atFull),
    .strobe  (strobe),
    .stageEn (stageEn)
  );

  ss_datapath #(
    .STEPS         (STEPS),
    .TICKS_PER_STEP(TICKS_PER_STEP)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .refCode(refCode),
    .atFull (atFull)
  );

  assign softDone = atFull;

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReq || !supplyOk) |=> (refCode == '0));

  // R2
  standby_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(enReq) && !enReq) |-> !stageEn);

endmodule

// File: tb/test_softstart_seq.sv
module test_softstart_seq;

  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swTick = 1'b0;
  logic       enReq = 1'b0;
  logic       supplyOk = 1'b0;
  logic [7:0] tempCode = 8'd25;
  logic [6:0] refCode;
  logic       stageEn;
  logic       softDone;

  int checks = 0;
  int failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  softstart_seq i_softstart_seq (
    .clk(clk), .rstN(rstN), .swTick(swTick), .enReq(enReq),
    .supplyOk(supplyOk), .tempCode(tempCode), .refCode(refCode),
    .stageEn(stageEn), .softDone(softDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); swTick = 1'b1;
      @(negedge clk); swTick = 1'b0;
    end
    #1;
  endtask

  task automatic startUp;
    @(negedge clk); enReq = 1'b1; supplyOk = 1'b1;
    cycles(1);
  endtask

  task automatic t_reset;
    chk("R1 code", refCode, 0);
    chk("R1 stageEn", stageEn, 0);
    chk("R1 done", softDone, 0);
  endtask

  task automatic t_standby;
    @(negedge clk); supplyOk = 1'b1; enReq = 1'b0;
    ticks(40);
    chk("R2 code en low", refCode, 0);
    chk("R2 stageEn en low", stageEn, 0);
    @(negedge clk); supplyOk = 1'b0; enReq = 1'b1;
    ticks(40);
    chk("R2 code supply low", refCode, 0);
    chk("R2 stageEn supply low", stageEn, 0);
    @(negedge clk); enReq = 1'b0;
  endtask

  task automatic t_fullRamp;
    startUp();
    chk("R3 stageEn", stageEn, 1);
    chk("R3 code first step", refCode, 0);
    cycles(20);
    chk("R4 no tick no step", refCode, 0);
    ticks(31);
    chk("R4 31 ticks", refCode, 0);
    ticks(1);
    chk("R4 32 ticks", refCode, 1);
    ticks(64);
    chk("R4 96 ticks", refCode, 3);
    ticks(2047 - 96);
    chk("R5 2047 ticks code", refCode, 63);
    chk("R5 2047 ticks done", softDone, 0);
    ticks(1);
    chk("R5 2048 ticks code", refCode, 64);
    chk("R5 2048 ticks done", softDone, 1);
    ticks(100);
    chk("R5 saturate code", refCode, 64);
    chk("R5 saturate done", softDone, 1);
    chk("R5 stageEn held", stageEn, 1);
  endtask

  task automatic t_enableDrop;
    @(negedge clk); enReq = 1'b0; #1;
    chk("R6 stageEn same cycle", stageEn, 0);
    cycles(1);
    chk("R6 code cleared", refCode, 0);
    chk("R6 done cleared", softDone, 0);
    startUp();
    ticks(31);
    chk("R6 restart 31 ticks", refCode, 0);
    ticks(1);
    chk("R6 restart 32 ticks", refCode, 1);
  endtask

  task automatic t_supplyDrop;
    ticks(64);
    chk("R6 pre supply drop", refCode, 3);
    @(negedge clk); supplyOk = 1'b0; #1;
    chk("R6 supply stageEn", stageEn, 0);
    cycles(1);
    chk("R6 supply code", refCode, 0);
    @(negedge clk); supplyOk = 1'b1;
    cycles(1);
    chk("R6 supply back stageEn", stageEn, 1);
    chk("R6 supply back code", refCode, 0);
  endtask

  task automatic t_thermal;
    @(negedge clk); tempCode = 8'd150;
    ticks(96);
    chk("R7 150 no trip stageEn", stageEn, 1);
    chk("R7 150 no trip code", refCode, 3);
    @(negedge clk); tempCode = 8'd151;
    cycles(1);
    chk("R7 trip stageEn", stageEn, 0);
    cycles(1);
    chk("R7 trip code", refCode, 0);
    @(negedge clk); tempCode = 8'd130;
    ticks(64);
    chk("R8 band stageEn", stageEn, 0);
    chk("R8 band code", refCode, 0);
    @(negedge clk); tempCode = 8'd121;
    ticks(64);
    chk("R8 121 still off", stageEn, 0);
    @(negedge clk); tempCode = 8'd120;
    cycles(2);
    chk("R8 release stageEn", stageEn, 1);
    chk("R8 release code", refCode, 0);
    ticks(32);
    chk("R8 ramp after release", refCode, 1);
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    cycles(3);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    cycles(2);
    t_reset();
    t_standby();
    t_fullRamp();
    t_enableDrop();
    t_supplyDrop();
    t_thermal();
    finishRun();
  end

endmodule